// File: doc/BRIEF.md
# Stepper Phase Sequencer with Boost One-Shot

This block turns a step/direction command stream into the four active-low winding drive signals of a two-phase stepper motor. An eight-position up/down counter holds the rotor position: four full-step positions with two windings energised, and four half-step positions between them with a single winding energised. Each falling edge of the step input moves the counter by one position (half-step mode) or to the next full-step position (full-step mode). A two-bit code marks which kind of half-step position is active.

A single shared one-shot, loaded from a cycle-count input, raises a boost enable for the A or the B winding pair whenever a step lands on a full-step position and switches one of that pair's windings on. The boost lets an external higher-voltage stage charge the winding faster. An inhibit input parks every phase and indicator output in the off state, while the counter goes on following step commands. The step, direction and mode inputs are asynchronous and are brought into the clock domain inside the block.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the position returns to the start state: phase_n = 4'b1010 (bit 3 = A1, bit 2 = A2, bit 1 = B1, bit 0 = B2, 0 = winding on), half_code = 2'b00, and both boost outputs are low.
- R2: The position changes only after a falling edge of step_in, seen through a two-flop synchroniser, and by exactly one move per edge. A step_in held low, or dir_in and full_mode_in changing without a step, leaves the outputs unchanged.
- R3: With full_mode_in high and dir_in high, successive steps visit 1010, 0110, 0101, 1001 and then 1010 again. With dir_in low the same cycle runs in reverse.
- R4: With full_mode_in low, each step moves one of eight positions. A half-step position lies between two full-step neighbours and has only the winding they share switched on (1110, 0111, 1101, 1011).
- R5: With full_mode_in high and the position on a half-step state, a step moves to the nearest full-step state in the selected direction.
- R6: half_code reads 00 in every full-step state, 01 when only an A winding is on, and 10 when only a B winding is on.
- R7: While inhibit_in is high, phase_n reads 4'b1111 and half_code reads 2'b11. Steps taken during inhibit still move the position, which appears once inhibit_in returns low.
- R8: A step into a full-step state that switches an A winding on raises boost_a, and one that switches a B winding on raises boost_b, for exactly ton_cycles clock cycles. A step into a half-step state raises neither.
- R9: A new trigger while the one-shot runs restarts it on the newly selected line and drops the other. boost_a and boost_b are never high together.
- R10: While boost_hold is high, the line selected by the most recent trigger stays asserted after its count has run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also used as power-good |
| step_in | input | 1 | Asynchronous step command, acts on its falling edge |
| dir_in | input | 1 | Direction: 1 forward, 0 reverse |
| full_mode_in | input | 1 | 1 full-step mode, 0 half-step mode |
| inhibit_in | input | 1 | 1 forces phase and indicator outputs off |
| ton_cycles | input | TON_W | One-shot length in clock cycles |
| boost_hold | input | 1 | 1 keeps the selected boost line asserted |
| phase_n | output | 4 | Active-low winding drives {A1, A2, B1, B2} |
| half_code | output | 2 | Half-step indicator code |
| boost_a | output | 1 | Boost enable for the A winding pair |
| boost_b | output | 1 | Boost enable for the B winding pair |

## Verification
On every cycle the assertions check the inhibit mask, that the position moves only in a cycle after a detected step edge, that the phase pattern and half-step code agree on one or two windings on, that the two boost lines never overlap, that a boost rise always follows a step edge, and the start state that follows reset. The stepping sequences in both directions and modes, the snap from half-step to full-step, the boost length against ton_cycles, the hand-over on a retrigger, the hold behaviour and the replay of a position hidden by inhibit can only be shown by the bench's scenarios, which compare each result with a position model worked out from the requirements.

// File: rtl/stp_pkg.sv
// Package stp_pkg
// Shared position type and the pure decode/advance functions of the sequencer.
// Assumes position 0 is the start state and even positions are full steps.
package stp_pkg;

    localparam int POS_W = 3;
    typedef logic [POS_W-1:0] pos_t;

    // Active-low winding pattern {A1, A2, B1, B2} for each position.
    function automatic logic [3:0] phase_of(pos_t p);
        logic [3:0] r;
        case (p)
            3'd0:    r = 4'b1010;
            3'd1:    r = 4'b1110;
            3'd2:    r = 4'b0110;
            3'd3:    r = 4'b0111;
            3'd4:    r = 4'b0101;
            3'd5:    r = 4'b1101;
            3'd6:    r = 4'b1001;
            default: r = 4'b1011;
        endcase
        return r;
    endfunction

    // Half-step code: 00 full step, 01 only an A winding on, 10 only a B winding on.
    function automatic logic [1:0] half_of(pos_t p);
        logic [1:0] r;
        if (!p[0])     r = 2'b00;
        else if (p[1]) r = 2'b01;
        else           r = 2'b10;
        return r;
    endfunction

    // Next position for a step; full mode always lands on an even position.
    function automatic pos_t next_pos(pos_t p, logic fwd, logic full);
        pos_t r;
        if (!full)    r = fwd ? pos_t'(p + 3'd1) : pos_t'(p - 3'd1);
        else if (fwd) r = pos_t'(p + 3'd2) & 3'b110;
        else          r = pos_t'(p - 3'd1) & 3'b110;
        return r;
    endfunction

endpackage

// File: rtl/stp_sync.sv
// Module stp_sync
// Multi-bit, multi-stage flop synchroniser for independent asynchronous levels.
// Assumes each bit is a slow level, so no bus coherency is required.
module stp_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/stp_position.sv
// Module stp_position
// Falling-edge detector and eight-position up/down counter. Produces one-cycle
// boost triggers when a step enters a full-step state and turns a winding on.
// Assumes synchronised inputs and that direction/mode are aligned with step.
module stp_position
    import stp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_s,
    input  logic dir_s,
    input  logic full_s,
    output pos_t pos_q,
    output logic fall,
    output logic trig_a,
    output logic trig_b
);

    logic       step_prev_q;
    pos_t       pos_nx;
    logic [3:0] turn_on;

    // Remember last synchronised step level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) step_prev_q <= 1'b1;
        else        step_prev_q <= step_s;
    end

    assign fall   = step_prev_q & ~step_s;
    assign pos_nx = next_pos(pos_q, dir_s, full_s);

    // Position register moves once per detected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos_q <= '0;
        else if (fall) pos_q <= pos_nx;
    end

    // Windings that are off now and on in the target state.
    always_comb begin
        turn_on = phase_of(pos_q) & ~phase_of(pos_nx);
        trig_a  = fall & ~pos_nx[0] & (|turn_on[3:2]);
        trig_b  = fall & ~pos_nx[0] & ~(|turn_on[3:2]) & (|turn_on[1:0]);
    end

endmodule

// File: rtl/stp_boost.sv
// Module stp_boost
// Single shared one-shot feeding two boost lines. A trigger loads the length,
// selects the line, and restarts any pulse already running.
// Assumes trig_a and trig_b are single-cycle and not both high.
module stp_boost #(
    parameter int TON_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_a,
    input  logic             trig_b,
    input  logic [TON_W-1:0] ton,
    input  logic             hold,
    output logic             boost_a,
    output logic             boost_b
);

    logic [TON_W-1:0] cnt_q;
    logic             sel_b_q;
    logic             fired_q;
    logic             active;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sel_b_q <= 1'b0;
            fired_q <= 1'b0;
        end else if (trig_a || trig_b) begin
            cnt_q   <= ton;
            sel_b_q <= trig_b;
            fired_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign active  = (cnt_q != '0) | (hold & fired_q);
    assign boost_a = active & ~sel_b_q;
    assign boost_b = active &  sel_b_q;

endmodule

// File: rtl/stepper_phase_seq.sv
// Module stepper_phase_seq
// Top of the stepper phase sequencer: synchronises step/direction/mode,
// tracks position, decodes windings and half-step code, applies inhibit and
// drives the boost one-shot. Assumes rst_n is synchronous to clk.
module stepper_phase_seq
    import stp_pkg::*;
#(
    parameter int TON_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic             full_mode_in,
    input  logic             inhibit_in,
    input  logic [TON_W-1:0] ton_cycles,
    input  logic             boost_hold,
    output logic [3:0]       phase_n,
    output logic [1:0]       half_code,
    output logic             boost_a,
    output logic             boost_b
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;
    pos_t             pos_q;
    logic             step_fall;
    logic             trig_a;
    logic             trig_b;

    stp_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in ({step_in, dir_in, full_mode_in}),
        .q_out(sync_q)
    );

    stp_position u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step_s(sync_q[2]),
        .dir_s (sync_q[1]),
        .full_s(sync_q[0]),
        .pos_q (pos_q),
        .fall  (step_fall),
        .trig_a(trig_a),
        .trig_b(trig_b)
    );

    stp_boost #(
        .TON_W(TON_W)
    ) u_boost (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_a (trig_a),
        .trig_b (trig_b),
        .ton    (ton_cycles),
        .hold   (boost_hold),
        .boost_a(boost_a),
        .boost_b(boost_b)
    );

    // Output decode with inhibit mask forcing everything off.
    always_comb begin
        if (inhibit_in) begin
            phase_n   = 4'b1111;
            half_code = 2'b11;
        end else begin
            phase_n   = phase_of(pos_q);
            half_code = half_of(pos_q);
        end
    end

endmodule

// File: rtl/stepper_phase_seq_chk.sv
// Module stepper_phase_seq_chk
// Cycle-by-cycle properties of the sequencer, bound into the top module.
// Assumes the bound signals step_fall and pos_q exist in the top.
module stepper_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit_in,
    input logic       boost_hold,
    input logic [3:0] phase_n,
    input logic [1:0] half_code,
    input logic       boost_a,
    input logic       boost_b,
    input logic       fall,
    input logic [2:0] pos
);

    logic was_rst_q;

    // Track whether the previous edge applied reset.
    always_ff @(posedge clk) begin
        was_rst_q <= !rst_n;
        if (rst_n && was_rst_q && !inhibit_in)
            assert_reset_state_R1: assert (phase_n == 4'b1010 && half_code == 2'b00
                                           && !boost_a && !boost_b);
    end

    assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(pos));

    assert_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_in |-> (($countones(~phase_n) == 2 && half_code == 2'b00) ||
                         ($countones(~phase_n) == 1 && half_code != 2'b00)));

    assert_inhibit_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_in |-> (phase_n == 4'b1111 && half_code == 2'b11));

    assert_boost_a_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(boost_a) && !$rose(boost_hold)) |-> $past(fall));

    assert_boost_b_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(boost_b) && !$rose(boost_hold)) |-> $past(fall));

    assert_boost_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(boost_a && boost_b));

endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit_in(inhibit_in),
    .boost_hold(boost_hold),
    .phase_n   (phase_n),
    .half_code (half_code),
    .boost_a   (boost_a),
    .boost_b   (boost_b),
    .fall      (step_fall),
    .pos       (pos_q)
);

// File: tb/sim_stepper_phase_seq.sv
module sim_stepper_phase_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_in = 1'b1;
    logic       dir_in = 1'b1;
    logic       full_mode_in = 1'b1;
    logic       inhibit_in = 1'b0;
    logic [7:0] ton_cycles = 8'd20;
    logic       boost_hold = 1'b0;
    logic [3:0] phase_n;
    logic [1:0] half_code;
    logic       boost_a;
    logic       boost_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stepper_phase_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_in     (step_in),
        .dir_in      (dir_in),
        .full_mode_in(full_mode_in),
        .inhibit_in  (inhibit_in),
        .ton_cycles  (ton_cycles),
        .boost_hold  (boost_hold),
        .phase_n     (phase_n),
        .half_code   (half_code),
        .boost_a     (boost_a),
        .boost_b     (boost_b)
    );

    // {dir, full, phase_n[3:0], half_code[1:0], boost_a, boost_b}
    localparam logic [9:0] VEC [15] = '{
        {1'b1, 1'b1, 4'b0110, 2'b00, 1'b1, 1'b0},  // R3 forward full
        {1'b1, 1'b1, 4'b0101, 2'b00, 1'b0, 1'b1},  // R3 R8 B turns on
        {1'b1, 1'b0, 4'b1101, 2'b10, 1'b0, 1'b0},  // R4 R6 half state, no boost
        {1'b1, 1'b1, 4'b1001, 2'b00, 1'b1, 1'b0},  // R5 snap to full
        {1'b0, 1'b0, 4'b1101, 2'b10, 1'b0, 1'b0},  // R4 reverse half
        {1'b0, 1'b0, 4'b0101, 2'b00, 1'b1, 1'b0},  // R4 R8 reverse into full
        {1'b0, 1'b1, 4'b0110, 2'b00, 1'b0, 1'b1},  // R3 reverse full
        {1'b0, 1'b1, 4'b1010, 2'b00, 1'b1, 1'b0},  // R3 reverse full
        {1'b0, 1'b1, 4'b1001, 2'b00, 1'b0, 1'b1},  // R3 reverse wrap
        {1'b1, 1'b0, 4'b1011, 2'b01, 1'b0, 1'b0},  // R4 R6 A-only half
        {1'b1, 1'b1, 4'b1010, 2'b00, 1'b0, 1'b1},  // R5 forward wrap snap
        {1'b1, 1'b0, 4'b1110, 2'b10, 1'b0, 1'b0},  // R4 half
        {1'b1, 1'b0, 4'b0110, 2'b00, 1'b1, 1'b0},  // R4 R8 half into full
        {1'b1, 1'b0, 4'b0111, 2'b01, 1'b0, 1'b0},  // R6 A-only half
        {1'b0, 1'b1, 4'b0110, 2'b00, 1'b0, 1'b1}   // R5 reverse snap
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Set direction/mode, then drop step on the following negedge.
    task automatic step_low(input logic d, input logic f);
        dir_in = d;
        full_mode_in = f;
        tick(1);
        step_in = 1'b0;
    endtask

    task automatic count_high(input int window, output int na, output int nb);
        na = 0;
        nb = 0;
        for (int i = 0; i < window; i++) begin
            tick(1);
            if (boost_a) na++;
            if (boost_b) nb++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int na;
        int nb;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R1 reset phase", {4'h0, phase_n}, 8'h0A);
        check("R1 reset half", {6'h0, half_code}, 8'h00);
        check("R1 reset boost", {6'h0, boost_a, boost_b}, 8'h00);

        // Vector walk: boost still running 6 cycles after each step.
        for (int v = 0; v < 15; v++) begin
            step_low(VEC[v][9], VEC[v][8]);
            tick(6);
            check($sformatf("R3/R4 vec%0d phase", v), {4'h0, phase_n}, {4'h0, VEC[v][7:4]});
            check($sformatf("R6 vec%0d half", v), {6'h0, half_code}, {6'h0, VEC[v][3:2]});
            check($sformatf("R8 vec%0d boost", v), {6'h0, boost_a, boost_b}, {6'h0, VEC[v][1:0]});
            step_in = 1'b1;
            tick(40);
        end

        // R7: inhibit masks, counter keeps tracking (now at 0110).
        inhibit_in = 1'b1;
        tick(2);
        check("R7 mask phase", {4'h0, phase_n}, 8'h0F);
        check("R7 mask half", {6'h0, half_code}, 8'h03);
        step_low(1'b1, 1'b1);
        tick(8);
        check("R7 mask during step", {4'h0, phase_n}, 8'h0F);
        step_in = 1'b1;
        tick(40);
        inhibit_in = 1'b0;
        tick(1);
        check("R7 tracked position", {4'h0, phase_n}, 8'h05);

        // R2: direction/mode changes without a step are ignored.
        dir_in = 1'b0;
        full_mode_in = 1'b0;
        tick(10);
        check("R2 no step no move", {4'h0, phase_n}, 8'h05);

        // R2: step held low long gives exactly one move (0101 -> 1101).
        step_low(1'b1, 1'b0);
        tick(60);
        check("R2 one move per edge", {4'h0, phase_n}, 8'h0D);
        step_in = 1'b1;
        tick(10);

        // R8: pulse length equals ton_cycles (1101 -> 1001, A turns on).
        step_low(1'b1, 1'b1);
        count_high(80, na, nb);
        check("R8 boost_a length", 8'(na), 8'd20);
        check("R8 boost_b idle", 8'(nb), 8'd0);
        step_in = 1'b1;
        tick(10);

        // R9: retrigger moves the one-shot to the other line.
        ton_cycles = 8'd40;
        step_low(1'b1, 1'b1);          // 1001 -> 1010, B turns on
        tick(5);
        check("R9 first line b", {6'h0, boost_a, boost_b}, 8'h01);
        step_in = 1'b1;
        tick(5);
        step_low(1'b1, 1'b1);          // 1010 -> 0110, A turns on
        tick(6);
        check("R9 retrigger switch", {6'h0, boost_a, boost_b}, 8'h02);
        tick(34);
        check("R9 restart full length", {6'h0, boost_a, boost_b}, 8'h02);
        tick(10);
        check("R9 pulse ends", {6'h0, boost_a, boost_b}, 8'h00);
        step_in = 1'b1;
        tick(10);

        // R10: hold keeps the selected line asserted (0110 -> 0101, B).
        ton_cycles = 8'd5;
        boost_hold = 1'b1;
        step_low(1'b1, 1'b1);
        tick(30);
        check("R10 hold keeps b", {6'h0, boost_a, boost_b}, 8'h01);
        boost_hold = 1'b0;
        tick(1);
        check("R10 release drops", {6'h0, boost_a, boost_b}, 8'h00);
        step_in = 1'b1;
        tick(10);

        // R1: reset in mid-run returns to the start state.
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1 rerun phase", {4'h0, phase_n}, 8'h0A);
        check("R1 rerun half", {6'h0, half_code}, 8'h00);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule